// File: doc/BRIEF.md
# Dual-Channel PCM Serial Frame Transmitter

This block sends one 28-bit outbound word on a single serial line each time the frame-sync input rises. The word holds one companded sample byte for each of two voice channels, six echo (status-latch) bits, one power-down flag per channel and four filler bits. Bits leave most significant first, one per rising bit-clock edge, and the block runs entirely on the bit clock. The line is open-drain. The block never drives a high level; it only asserts a pull-low request for data bits equal to 0. Whenever it is not sending a bit, the line is released.

A frame starts when the block sees frame sync high on a bit-clock edge after it saw it low on the previous edge. On that edge the transmitter captures all frame inputs into a shadow register. With the default early-launch variant, the first bit also appears on that same edge. The late variant waits one more edge before the first bit. For a channel flagged as powered down, the transmitter sends the positive-zero code of the selected companding law in place of that channel's sample byte. Driving the power input low releases the line and returns every internal register to 0.

The sequencer has four states: OFF (powered down), IDLE (waiting for sync), ARM (capture done, first bit pending; late variant only) and SHIFT (sending bits). It has these transitions:
- any state to OFF when the power input is low;
- OFF to IDLE when the power input is high;
- IDLE to SHIFT (early) or IDLE to ARM (late) on a sync rise;
- ARM to SHIFT;
- SHIFT to IDLE after the last bit;
- SHIFT to SHIFT (early) or SHIFT to ARM (late) on a sync rise in the middle of a frame.

Top module: `pcm_frame_tx`

## Requirements
- R1: After reset, and one edge after the power input is sampled low, the pull-low output is 0. No frame is sent until a new sync rise occurs after power returns.
- R2: Frame bit order, first to last: channel 1 byte (bit 7 first), then channel 2 byte (bit 7 first), then echo bits 5 down to 0, then the channel 1 power-down flag, then the channel 2 power-down flag, then four filler bits of value 1.
- R3: With early launch, the first frame bit is visible right after the edge that samples the sync rise. Each following bit appears one edge later, for 28 bits in total.
- R4: After the 28th bit, the line is released from the next edge until the next sync rise.
- R5: Frame inputs are captured at frame start. Changes to them during a frame do not alter the frame being sent.
- R6: The law-select input chooses A-law when 1 and mu-law when 0. A channel whose power-down flag is 1 sends the positive-zero code: 0xFF for mu-law, 0xD5 for A-law. Any other byte, such as the full-scale codes 0x80/0x00 (mu-law) and 0xAA/0x2A (A-law), is sent unchanged.
- R7: A power-down in the middle of a frame abandons that frame. The line stays released after power returns until the next sync rise.
- R8: A sync rise in the middle of a frame restarts the sequence with freshly captured inputs.
- R9: Frame sync held high starts only one frame. Only a low-to-high change starts a frame.
- R10: The line is pulled low only for frame bits equal to 0. Filler bits never pull it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; every bit changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_up | input | 1 | 1 = operate, 0 = power down and clear all registers |
| fsync | input | 1 | Frame sync; a low-to-high change starts a frame |
| law_sel | input | 1 | 1 = A-law, 0 = mu-law |
| ch_pd | input | 2 | Per-channel power-down flags, bit 0 = channel 1 |
| ch1_code | input | 8 | Channel 1 companded sample |
| ch2_code | input | 8 | Channel 2 companded sample |
| echo_bits | input | 6 | Echo/status bits placed after the samples |
| line_pull_low | output | 1 | 1 = pull the open-drain line low; 0 = release |

## Verification
The bench builds the block with its default parameters: 8-bit codes, six echo bits, four filler bits and early launch. This gives the 28-bit frame and puts the first bit on the sync-sampling edge, so bit timing is checked from that edge. The sample table covers the full-scale and zero codes of both laws, and the per-channel power-down substitution under each law. Directed runs cover changing inputs during a frame, restarting a frame, holding sync high, and powering down in the middle of a frame.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_ARM   = 2'd2,
        ST_SHIFT = 2'd3
    } tx_state_e;

    localparam int NUM_CH = 2;

endpackage

// File: rtl/pcm_sync_detect.sv
module pcm_sync_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_up,
    input  logic fsync,
    output logic sync_rise
);

    logic fsync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsync_q <= 1'b0;
        end else if (!pwr_up) begin
            fsync_q <= 1'b0;
        end else begin
            fsync_q <= fsync;
        end
    end

    assign sync_rise = pwr_up && fsync && !fsync_q;

endmodule

// File: rtl/pcm_frame_build.sv
module pcm_frame_build #(
    parameter int CODE_W  = 8,
    parameter int ECHO_W  = 6,
    parameter int FILL_W  = 4,
    localparam int FRAME_W = 2 * CODE_W + ECHO_W + 2 + FILL_W
) (
    input  logic               law_sel,
    input  logic [1:0]         ch_pd,
    input  logic [CODE_W-1:0]  ch1_code,
    input  logic [CODE_W-1:0]  ch2_code,
    input  logic [ECHO_W-1:0]  echo_bits,
    output logic [FRAME_W-1:0] frame
);

    logic [CODE_W-1:0] zero_code;
    logic [CODE_W-1:0] code_in  [2];
    logic [CODE_W-1:0] code_out [2];

    // Positive zero: all ones (mu-law) or 1 then alternating bits ending in 1 (A-law)
    always_comb begin
        for (int i = 0; i < CODE_W; i++) begin
            if (!law_sel || i == CODE_W - 1) begin
                zero_code[i] = 1'b1;
            end else begin
                zero_code[i] = (i % 2 == 0);
            end
        end
    end

    assign code_in[0] = ch1_code;
    assign code_in[1] = ch2_code;

    for (genvar g = 0; g < 2; g++) begin : g_chan
        assign code_out[g] = ch_pd[g] ? zero_code : code_in[g];
    end

    assign frame = {code_out[0], code_out[1], echo_bits, ch_pd[0], ch_pd[1], {FILL_W{1'b1}}};

endmodule

// File: rtl/pcm_frame_seq.sv
module pcm_frame_seq
    import pcm_tx_pkg::*;
#(
    parameter int FRAME_W      = 28,
    parameter int FILL_W       = 4,
    parameter bit EARLY_LAUNCH = 1'b1,
    localparam int CNT_W       = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_up,
    input  logic               sync_rise,
    input  logic [FRAME_W-1:0] frame_in,
    output logic               line_pull
);

    localparam logic [CNT_W-1:0] LAST_IDX   = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] FILL_START = CNT_W'(FRAME_W - FILL_W);

    tx_state_e          state, state_nx;
    logic [FRAME_W-1:0] shadow;
    logic [CNT_W-1:0]   cnt;
    logic               launch_now;
    logic               load;
    logic               start_bits;

    if (EARLY_LAUNCH) begin : g_early
        assign launch_now = 1'b1;
    end else begin : g_late
        assign launch_now = 1'b0;
    end

    assign load       = sync_rise && (state == ST_IDLE || state == ST_SHIFT);
    assign start_bits = (load && launch_now) || (state == ST_ARM);

    always_comb begin
        state_nx = state;
        if (!pwr_up) begin
            state_nx = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:   state_nx = ST_IDLE;
                ST_IDLE:  if (sync_rise) state_nx = launch_now ? ST_SHIFT : ST_ARM;
                ST_ARM:   state_nx = ST_SHIFT;
                ST_SHIFT: begin
                    if (sync_rise)              state_nx = launch_now ? ST_SHIFT : ST_ARM;
                    else if (cnt == LAST_IDX)   state_nx = ST_IDLE;
                end
                default:  state_nx = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow    <= '0;
            cnt       <= '0;
            line_pull <= 1'b0;
        end else if (!pwr_up) begin
            shadow    <= '0;
            cnt       <= '0;
            line_pull <= 1'b0;
        end else begin
            if (load) begin
                shadow <= frame_in;
            end
            if (start_bits) begin
                cnt       <= '0;
                line_pull <= load ? !frame_in[FRAME_W-1] : !shadow[FRAME_W-1];
            end else if (state == ST_SHIFT && !load && cnt != LAST_IDX) begin
                cnt       <= cnt + 1'b1;
                line_pull <= !shadow[FRAME_W - 2 - int'(cnt)];
            end else begin
                line_pull <= 1'b0;
            end
        end
    end

    // R1
    pd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_up |=> !line_pull);

    // R4
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n || !pwr_up)
        (state == ST_IDLE && !sync_rise) |=> !line_pull);

    // R10
    filler_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && cnt >= FILL_START) |-> !line_pull);

    // R5
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !pwr_up)
        (state == ST_SHIFT && !sync_rise) |=> $stable(shadow));

    // R3
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_IDX);

endmodule

// File: rtl/pcm_frame_tx.sv
module pcm_frame_tx #(
    parameter int CODE_W       = 8,
    parameter int ECHO_W       = 6,
    parameter int FILL_W       = 4,
    parameter bit EARLY_LAUNCH = 1'b1,
    localparam int FRAME_W     = 2 * CODE_W + ECHO_W + 2 + FILL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_up,
    input  logic              fsync,
    input  logic              law_sel,
    input  logic [1:0]        ch_pd,
    input  logic [CODE_W-1:0] ch1_code,
    input  logic [CODE_W-1:0] ch2_code,
    input  logic [ECHO_W-1:0] echo_bits,
    output logic              line_pull_low
);

    logic               sync_rise;
    logic [FRAME_W-1:0] frame_word;

    pcm_sync_detect u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_up    (pwr_up),
        .fsync     (fsync),
        .sync_rise (sync_rise)
    );

    pcm_frame_build #(
        .CODE_W (CODE_W),
        .ECHO_W (ECHO_W),
        .FILL_W (FILL_W)
    ) u_build (
        .law_sel   (law_sel),
        .ch_pd     (ch_pd),
        .ch1_code  (ch1_code),
        .ch2_code  (ch2_code),
        .echo_bits (echo_bits),
        .frame     (frame_word)
    );

    pcm_frame_seq #(
        .FRAME_W      (FRAME_W),
        .FILL_W       (FILL_W),
        .EARLY_LAUNCH (EARLY_LAUNCH)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_up    (pwr_up),
        .sync_rise (sync_rise),
        .frame_in  (frame_word),
        .line_pull (line_pull_low)
    );

endmodule

// File: tb/pcm_frame_tx_test.sv
module pcm_frame_tx_test;

    localparam int CLK_P = 10;
    localparam int NVEC  = 7;

    // {law_sel, ch_pd[1:0], ch1_code, ch2_code, echo_bits}
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b0, 2'b00, 8'h80, 8'h00, 6'b101010},
        {1'b0, 2'b00, 8'hFF, 8'h7F, 6'b000000},
        {1'b1, 2'b00, 8'hAA, 8'h2A, 6'b111111},
        {1'b1, 2'b00, 8'hD5, 8'h55, 6'b010011},
        {1'b0, 2'b01, 8'h00, 8'h12, 6'b000001},
        {1'b1, 2'b10, 8'h3C, 8'h00, 6'b100000},
        {1'b1, 2'b11, 8'h00, 8'h00, 6'b011110}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_up = 1'b0;
    logic       fsync = 1'b0;
    logic       law_sel = 1'b0;
    logic [1:0] ch_pd = 2'b00;
    logic [7:0] ch1_code = 8'h00;
    logic [7:0] ch2_code = 8'h00;
    logic [5:0] echo_bits = 6'b0;
    logic       line_pull_low;

    int tests = 0;
    int fails = 0;

    always #(CLK_P / 2) clk = ~clk;

    pcm_frame_tx uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwr_up        (pwr_up),
        .fsync         (fsync),
        .law_sel       (law_sel),
        .ch_pd         (ch_pd),
        .ch1_code      (ch1_code),
        .ch2_code      (ch2_code),
        .echo_bits     (echo_bits),
        .line_pull_low (line_pull_low)
    );

    function automatic logic [27:0] exp_frame(logic law, logic [1:0] pd, logic [7:0] c1,
                                              logic [7:0] c2, logic [5:0] e);
        logic [7:0] z;
        z = law ? 8'hD5 : 8'hFF;
        return {pd[0] ? z : c1, pd[1] ? z : c2, e, pd[0], pd[1], 4'b1111};
    endfunction

    task automatic check(string req, logic [27:0] got, logic [27:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply(logic [24:0] v);
        {law_sel, ch_pd, ch1_code, ch2_code, echo_bits} = v;
    endtask

    // one edge, then sample the line level at the falling edge
    task automatic step_bit(output logic b);
        @(posedge clk);
        @(negedge clk);
        b = !line_pull_low;
    endtask

    // caller is at a negedge with sync low; raises sync and collects n bits
    task automatic collect(int n, bit hold_sync, output logic [27:0] got);
        logic b;
        got = '1;
        fsync = 1'b1;
        for (int k = 0; k < n; k++) begin
            step_bit(b);
            got[27-k] = b;
            if (k == 0 && !hold_sync) fsync = 1'b0;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [27:0] got;
        logic        b;
        logic [27:0] e1;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset", {27'd0, line_pull_low}, 28'd0);
        rst_n = 1'b1;
        pwr_up = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle after power", {27'd0, line_pull_low}, 28'd0);

        // R2 R6 R10 table of frames
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i]);
            collect(28, 1'b0, got);
            check("R2/R6 frame", got, exp_frame(VEC[i][24], VEC[i][23:22], VEC[i][21:14],
                                                VEC[i][13:6], VEC[i][5:0]));
            check("R10 filler", {24'd0, got[3:0]}, {24'd0, 4'b1111});
            step_bit(b);
            check("R4 release after last", {27'd0, b}, 28'd1);
            repeat (2) @(negedge clk);
        end

        // R3 first bit timing: line released before the sync edge, low right after
        apply({1'b0, 2'b00, 8'h00, 8'h00, 6'b0});
        check("R3 before launch", {27'd0, line_pull_low}, 28'd0);
        fsync = 1'b1;
        @(posedge clk);
        @(negedge clk);
        fsync = 1'b0;
        check("R3 first bit on sync edge", {27'd0, line_pull_low}, 28'd1);
        repeat (30) @(negedge clk);

        // R5 inputs change mid-frame
        apply({1'b0, 2'b00, 8'h5A, 8'hC3, 6'b110011});
        e1 = exp_frame(1'b0, 2'b00, 8'h5A, 8'hC3, 6'b110011);
        got = '1;
        fsync = 1'b1;
        for (int k = 0; k < 28; k++) begin
            step_bit(b);
            got[27-k] = b;
            if (k == 0) fsync = 1'b0;
            if (k == 3) apply({1'b1, 2'b11, 8'h00, 8'h00, 6'b000000});
        end
        check("R5 shadow capture", got, e1);
        repeat (3) @(negedge clk);

        // R9 sync held high: one frame only
        apply({1'b0, 2'b00, 8'h00, 8'h00, 6'b000000});
        collect(28, 1'b1, got);
        check("R9 first frame", got, exp_frame(1'b0, 2'b00, 8'h00, 8'h00, 6'b0));
        got = '1;
        for (int k = 0; k < 10; k++) begin
            step_bit(b);
            got[27-k] = b;
        end
        check("R9 no retrigger", got, 28'hFFFFFFF);
        fsync = 1'b0;
        repeat (3) @(negedge clk);

        // R7 power-down mid-frame
        collect(5, 1'b0, got);
        pwr_up = 1'b0;
        step_bit(b);
        check("R7 released in power-down", {27'd0, b}, 28'd1);
        pwr_up = 1'b1;
        got = '1;
        for (int k = 0; k < 30; k++) begin
            step_bit(b);
            got[27-k] = b;
        end
        check("R7 R1 no resume", got, 28'hFFFFFFF);
        collect(28, 1'b0, got);
        check("R7 next frame ok", got, exp_frame(1'b0, 2'b00, 8'h00, 8'h00, 6'b0));
        repeat (3) @(negedge clk);

        // R8 restart mid-frame with new data
        apply({1'b0, 2'b00, 8'hFF, 8'hFF, 6'b111111});
        collect(10, 1'b0, got);
        apply({1'b1, 2'b00, 8'h2A, 8'h81, 6'b001100});
        collect(28, 1'b0, got);
        check("R8 restart frame", got, exp_frame(1'b1, 2'b00, 8'h2A, 8'h81, 6'b001100));
        step_bit(b);
        check("R4 release after restart", {27'd0, b}, 28'd1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule